// File: doc/BRIEF.md
# Floating-Point Compare Unit with Sticky Invalid Flags

This block compares two IEEE 754 operands that arrive as raw bit patterns. It returns a 4-bit condition code that holds exactly one of less, greater, equal or unordered. A request writes that code into one selected field of an eight-field condition register, and also into a status copy of the last compare result. The same request updates a set of sticky invalid-operation flags.

The flags follow the operand classes and the compare variant. Signalling NaNs are told apart from quiet NaNs. The ordered variant can raise an invalid-compare flag, and the invalid-operation enable input decides that case when a signalling NaN is present. In packed-single mode, the block compares one 32-bit half of each operand instead of the full double. A lane select picks which half.

A request is accepted on any clock edge where `req_valid` is high. Every output is registered and shows the result of that request from the next edge on.

Top module: `fcmp_unit`

## Requirements
- R1: When either selected operand is a NaN, the code is unordered. A NaN has an all-ones exponent and a nonzero fraction. The code is 4'b0001 for unordered, 4'b1000 for less, 4'b0100 for greater and 4'b0010 for equal.
- R2: When neither operand is a NaN, the code has exactly one bit set and gives the numeric order of a against b. The infinities are ordered like numbers, and +0 equals -0.
- R3: Field k of `cond_reg` occupies bits [31-4k : 28-4k]. A request writes the code into field `dest_sel` and leaves the other seven fields unchanged.
- R4: `fp_cc` holds the code of the most recent request.
- R5: A signalling NaN operand sets `sticky_snan` in both variants. A signalling NaN has an all-ones exponent, a nonzero fraction and a clear top fraction bit.
- R6: In the ordered variant (`ordered`=1) with a signalling NaN operand, `sticky_cmp_inv` is set only if `inv_enable` is 1.
- R7: In the ordered variant, when the only NaNs are quiet ones, `sticky_cmp_inv` is set whatever `inv_enable` is.
- R8: In the unordered variant (`ordered`=0), quiet NaNs and ordinary numbers change no flag.
- R9: `sticky_inv_sum` ORs in `sticky_cmp_inv`, and `sticky_exc_sum` ORs in `sticky_inv_sum`. All four flags stay set until reset.
- R10: With `single_mode`=1, the block compares 32-bit single-precision values. `lane_sel`=0 takes bits [31:0] of each operand and `lane_sel`=1 takes bits [63:32]. The other half has no effect on the code or on the flags.
- R11: A cycle with `req_valid` low leaves every output unchanged.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Compare request this cycle |
| op_a | input | 64 | Operand a bit pattern |
| op_b | input | 64 | Operand b bit pattern |
| ordered | input | 1 | 1 = ordered variant, 0 = unordered variant |
| inv_enable | input | 1 | Invalid-operation enable bit |
| single_mode | input | 1 | Compare packed single-precision halves |
| lane_sel | input | 1 | Half used in single mode (0 low, 1 high) |
| dest_sel | input | 3 | Destination condition field |
| cond_reg | output | 32 | Eight 4-bit condition fields |
| fp_cc | output | 4 | Copy of the last condition code |
| sticky_snan | output | 1 | Signalling-NaN invalid flag |
| sticky_cmp_inv | output | 1 | Invalid-compare flag |
| sticky_inv_sum | output | 1 | Invalid summary flag |
| sticky_exc_sum | output | 1 | Exception summary flag |

## Verification
The hardest case to reach is the split in R6: an ordered compare with a signalling NaN under each setting of `inv_enable`. The sticky flags would hide any difference between the two settings. To avoid that, the stimulus pulses reset between the two flag-raising sequences, so each sequence starts from clear flags. A single-mode lane whose other half carries a signalling NaN confirms that only the selected half is classified.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    typedef logic [3:0] ccode_t;
    localparam ccode_t CC_LT = 4'b1000;
    localparam ccode_t CC_GT = 4'b0100;
    localparam ccode_t CC_EQ = 4'b0010;
    localparam ccode_t CC_UN = 4'b0001;
endpackage

// File: rtl/fcmp_lane_mux.sv
module fcmp_lane_mux #(
    parameter int LANE_W = 32
) (
    input  logic [2*LANE_W-1:0] a_in,
    input  logic [2*LANE_W-1:0] b_in,
    input  logic                lane,
    output logic [LANE_W-1:0]   a_out,
    output logic [LANE_W-1:0]   b_out
);
    always_comb begin
        if (lane) begin
            a_out = a_in[2*LANE_W-1:LANE_W];
            b_out = b_in[2*LANE_W-1:LANE_W];
        end else begin
            a_out = a_in[LANE_W-1:0];
            b_out = b_in[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output ccode_t                code,
    output logic                  any_nan,
    output logic                  any_snan
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [MAG_W-1:0] a_mag, b_mag;
    logic a_sign, b_sign, a_nan, b_nan, a_sn, b_sn, a_zero, b_zero;
    logic mag_less;

    always_comb begin
        a_sign = a[MAG_W];
        b_sign = b[MAG_W];
        a_mag  = a[MAG_W-1:0];
        b_mag  = b[MAG_W-1:0];
        a_nan  = (&a[MAG_W-1:FRAC_W]) && (|a[FRAC_W-1:0]);
        b_nan  = (&b[MAG_W-1:FRAC_W]) && (|b[FRAC_W-1:0]);
        a_sn   = a_nan && !a[FRAC_W-1];
        b_sn   = b_nan && !b[FRAC_W-1];
        a_zero = ~|a_mag;
        b_zero = ~|b_mag;
        mag_less = a_mag < b_mag;
        any_nan  = a_nan || b_nan;
        any_snan = a_sn || b_sn;

        if (any_nan)
            code = CC_UN;
        else if (a_zero && b_zero)
            code = CC_EQ;
        else if (a_sign != b_sign)
            code = a_sign ? CC_LT : CC_GT;
        else if (a_mag == b_mag)
            code = CC_EQ;
        else if (mag_less ^ a_sign)
            code = CC_LT;
        else
            code = CC_GT;
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int NFIELDS = 8,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [DP_EXP+DP_FRAC:0]     op_a,
    input  logic [DP_EXP+DP_FRAC:0]     op_b,
    input  logic                        ordered,
    input  logic                        inv_enable,
    input  logic                        single_mode,
    input  logic                        lane_sel,
    input  logic [$clog2(NFIELDS)-1:0]  dest_sel,
    output logic [NFIELDS*4-1:0]        cond_reg,
    output logic [3:0]                  fp_cc,
    output logic                        sticky_snan,
    output logic                        sticky_cmp_inv,
    output logic                        sticky_inv_sum,
    output logic                        sticky_exc_sum
);
    localparam int DP_W = 1 + DP_EXP + DP_FRAC;
    localparam int SP_W = 1 + SP_EXP + SP_FRAC;
    localparam int CR_W = NFIELDS * 4;

    typedef struct packed {
        logic [CR_W-1:0] cr;
        ccode_t          cc;
        logic            snan;
        logic            cvi;
        logic            inv;
        logic            exc;
    } state_t;

    state_t st_d, st_q;

    logic [SP_W-1:0] sa, sb;
    ccode_t dp_code, sp_code, sel_code;
    logic dp_nan, dp_snan, sp_nan, sp_snan, sel_nan, sel_snan;

    fcmp_lane_mux #(.LANE_W(SP_W)) u_lane (
        .a_in(op_a), .b_in(op_b), .lane(lane_sel), .a_out(sa), .b_out(sb)
    );

    fcmp_core #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
        .a(op_a), .b(op_b), .code(dp_code), .any_nan(dp_nan), .any_snan(dp_snan)
    );

    fcmp_core #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
        .a(sa), .b(sb), .code(sp_code), .any_nan(sp_nan), .any_snan(sp_snan)
    );

    always_comb begin
        sel_code = single_mode ? sp_code : dp_code;
        sel_nan  = single_mode ? sp_nan  : dp_nan;
        sel_snan = single_mode ? sp_snan : dp_snan;

        st_d = st_q;
        if (req_valid) begin
            for (int k = 0; k < NFIELDS; k++) begin
                if (dest_sel == k[$clog2(NFIELDS)-1:0])
                    st_d.cr[(NFIELDS-1-k)*4 +: 4] = sel_code;
            end
            st_d.cc = sel_code;
            if (sel_snan) begin
                st_d.snan = 1'b1;
                if (ordered && inv_enable)
                    st_d.cvi = 1'b1;
            end else if (sel_nan && ordered) begin
                st_d.cvi = 1'b1;
            end
            st_d.inv = st_q.inv | st_d.cvi;
            st_d.exc = st_q.exc | st_d.inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cond_reg       = st_q.cr;
    assign fp_cc          = st_q.cc;
    assign sticky_snan    = st_q.snan;
    assign sticky_cmp_inv = st_q.cvi;
    assign sticky_inv_sum = st_q.inv;
    assign sticky_exc_sum = st_q.exc;

    // R2
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $onehot(fp_cc));
    // R3
    field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (cond_reg[(NFIELDS-1-int'($past(dest_sel)))*4 +: 4] == fp_cc));
    // R9
    snan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_snan |=> sticky_snan);
    // R9
    summary_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_cmp_inv |-> sticky_inv_sum) and (sticky_inv_sum |-> sticky_exc_sum));
    // R8
    unord_no_cvi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ordered) |=> $stable(sticky_cmp_inv));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(cond_reg) && $stable(fp_cc) && $stable(sticky_exc_sum)));
    // R10
    sp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (DP_W == 2 * SP_W));
endmodule

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        ordered = 1'b0, inv_enable = 1'b0, single_mode = 1'b0, lane_sel = 1'b0;
    logic [2:0]  dest_sel = '0;
    logic [31:0] cond_reg;
    logic [3:0]  fp_cc;
    logic        sticky_snan, sticky_cmp_inv, sticky_inv_sum, sticky_exc_sum;

    int total = 0;
    int bad = 0;

    logic [31:0] e_cr;
    logic [3:0]  e_cc;
    logic        e_sn, e_cv, e_iv, e_ex;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
        .ordered(ordered), .inv_enable(inv_enable), .single_mode(single_mode),
        .lane_sel(lane_sel), .dest_sel(dest_sel), .cond_reg(cond_reg), .fp_cc(fp_cc),
        .sticky_snan(sticky_snan), .sticky_cmp_inv(sticky_cmp_inv),
        .sticky_inv_sum(sticky_inv_sum), .sticky_exc_sum(sticky_exc_sum)
    );

    function automatic real sp_val(input logic [31:0] x);
        int  e;
        real m, r;
        e = int'(x[30:23]);
        if (e == 255) r = $bitstoreal(64'h7FF0000000000000);
        else begin
            if (e == 0) begin m = real'(x[22:0]); e = 1; end
            else m = real'(x[22:0]) + 8388608.0;
            r = m * (2.0 ** (e - 150));
        end
        return x[31] ? -r : r;
    endfunction

    task automatic model(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] va, vb;
        bit  na, nb, sa, sb;
        real ra, rb;
        logic [3:0] code;
        if (single_mode) begin
            va = lane_sel ? {32'h0, a[63:32]} : {32'h0, a[31:0]};
            vb = lane_sel ? {32'h0, b[63:32]} : {32'h0, b[31:0]};
            na = (va[30:23] == 8'hFF) && (va[22:0] != 0);
            nb = (vb[30:23] == 8'hFF) && (vb[22:0] != 0);
            sa = na && !va[22];
            sb = nb && !vb[22];
            ra = sp_val(va[31:0]);
            rb = sp_val(vb[31:0]);
        end else begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            sa = na && !a[51];
            sb = nb && !b[51];
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
        end
        if (na || nb) code = 4'b0001;
        else if (ra < rb) code = 4'b1000;
        else if (ra > rb) code = 4'b0100;
        else code = 4'b0010;
        e_cr[(7 - int'(dest_sel))*4 +: 4] = code;
        e_cc = code;
        if (sa || sb) begin
            e_sn = 1'b1;
            if (ordered && inv_enable) e_cv = 1'b1;
        end else if ((na || nb) && ordered) e_cv = 1'b1;
        e_iv = e_iv | e_cv;
        e_ex = e_ex | e_iv;
    endtask

    task automatic check(input string tag);
        total++;
        if (cond_reg !== e_cr) begin
            bad++;
            $display("FAIL %s cond_reg actual=%h expected=%h", tag, cond_reg, e_cr);
        end
        total++;
        if (fp_cc !== e_cc) begin
            bad++;
            $display("FAIL %s fp_cc actual=%b expected=%b", tag, fp_cc, e_cc);
        end
        total++;
        if ({sticky_snan, sticky_cmp_inv, sticky_inv_sum, sticky_exc_sum} !== {e_sn, e_cv, e_iv, e_ex}) begin
            bad++;
            $display("FAIL %s flags actual=%b expected=%b", tag,
                {sticky_snan, sticky_cmp_inv, sticky_inv_sum, sticky_exc_sum}, {e_sn, e_cv, e_iv, e_ex});
        end
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        req_valid = 1'b0;
        e_cr = '0; e_cc = '0; e_sn = 0; e_cv = 0; e_iv = 0; e_ex = 0;
        @(negedge clk);
        check(tag);
        rst_n = 1'b1;
        @(negedge clk);
        check(tag);
    endtask

    task automatic cmp(input logic [63:0] a, input logic [63:0] b, input bit ord, input bit ie,
                       input bit sgl, input bit lane, input logic [2:0] dst, input string tag);
        req_valid = 1'b1; op_a = a; op_b = b; ordered = ord; inv_enable = ie;
        single_mode = sgl; lane_sel = lane; dest_sel = dst;
        model(a, b);
        @(negedge clk);
        check(tag);
        req_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        op_a = 64'h7FF0000000000001; op_b = 64'h7FF8000000000000;
        ordered = 1'b1; inv_enable = 1'b1; dest_sel = 3'd5;
        @(negedge clk);
        check(tag);
    endtask

    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DM1 = 64'hBFF0000000000000, DPZ = 64'h0, DNZ = 64'h8000000000000000;
    localparam logic [63:0] DPI = 64'h7FF0000000000000, DNI = 64'hFFF0000000000000;
    localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;

    initial begin
        @(negedge clk);
        do_reset("R12");
        cmp(D1, D2, 1, 0, 0, 0, 3'd0, "R2 less");
        cmp(D2, D1, 1, 0, 0, 0, 3'd7, "R2 greater");
        cmp(D1, D1, 0, 0, 0, 0, 3'd3, "R2 equal");
        cmp(DPZ, DNZ, 1, 1, 0, 0, 3'd1, "R2 zeros");
        cmp(DM1, D1, 1, 1, 0, 0, 3'd2, "R2 signs");
        cmp(DNI, DPI, 0, 0, 0, 0, 3'd4, "R2 inf");
        cmp(DM1, 64'hC000000000000000, 0, 0, 0, 0, 3'd5, "R2 negmag");
        cmp(D1, D2, 0, 0, 0, 0, 3'd3, "R3 overwrite");
        cmp(D2, D2, 0, 0, 0, 0, 3'd6, "R4");
        idle("R11");
        cmp(DQN, D1, 0, 1, 0, 0, 3'd0, "R8 qnan");
        cmp(D1, 64'hFFF8000000000001, 0, 1, 0, 0, 3'd1, "R1 R8");
        cmp(DSN, D1, 0, 1, 0, 0, 3'd2, "R5 unord");
        cmp(D1, D2, 1, 1, 0, 0, 3'd2, "R9 sticky");
        do_reset("R12 mid");
        cmp(D1, DSN, 1, 0, 0, 0, 3'd7, "R6 ie0");
        cmp(D1, D1, 1, 0, 0, 0, 3'd7, "R6 hold");
        cmp(DSN, DQN, 1, 1, 0, 0, 3'd6, "R6 ie1 R9");
        idle("R11 flags");
        do_reset("R12 again");
        cmp(DQN, DQN, 1, 0, 0, 0, 3'd4, "R7 ie0");
        do_reset("R12 r7");
        cmp(D2, DQN, 1, 1, 0, 0, 3'd4, "R7 ie1");
        do_reset("R12 sp");
        cmp({32'h40000000, 32'h3F800000}, {32'h3F800000, 32'h40000000}, 1, 1, 1, 0, 3'd0, "R10 lane0");
        cmp({32'h40000000, 32'h3F800000}, {32'h3F800000, 32'h40000000}, 1, 1, 1, 1, 3'd1, "R10 lane1");
        cmp({32'h7F800001, 32'h00000000}, {32'h7FC00000, 32'h80000000}, 1, 1, 1, 0, 3'd2, "R10 other half");
        cmp({32'h7F800001, 32'h00000000}, {32'h3F800000, 32'h80000000}, 1, 0, 1, 1, 3'd3, "R10 snan R5");
        cmp({32'h00000000, 32'h7FC00000}, {32'h0, 32'h3F800000}, 1, 0, 1, 0, 3'd4, "R10 qnan R7");
        cmp({32'hFF800000, 32'h00000001}, {32'h7F800000, 32'h00000002}, 0, 0, 1, 0, 3'd5, "R10 denorm");
        cmp({32'hFF800000, 32'h00000001}, {32'h7F800000, 32'h00000002}, 0, 0, 1, 1, 3'd6, "R10 inf");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule